// File: doc/BRIEF.md
# Multichannel Result Readout Pointer

This block is the device-side readout logic of a four-channel simultaneous-sampling converter. A one-cycle completion strobe delivers one 14-bit two's-complement result per channel. The block stores them in a small register file, drives an active-low interrupt, and latches how many channels the finished sequence used. A host then reads the results over a parallel bus using active-low chip-select and read strobes. Channel 1 comes first, and each further strobe steps to the next channel.

The read and select strobes are asynchronous to the block's clock. They pass through a synchronizer, and edges are detected on the system clock. The strobes are never used as clocks. A falling read edge with chip-select low releases the interrupt if it is pending. A rising read edge with chip-select low moves the pointer on. After the last converted channel has been read, the pointer wraps to channel 1. Further reads keep cycling until the next conversion reloads the file.

Top module: `chan_readout`

## Requirements
- R1: After reset, `int_n` is 1.
- R2: A `done_i` pulse stores every channel's result and moves the pointer to channel 1. It also latches the channel-count code `chan_cnt_i` (code k means k+1 channels, k = 0..3) and drives `int_n` to 0 on the next rising clock edge.
- R3: A qualified falling edge of `rd_n` releases a pending `int_n` to 1. A falling edge is qualified when `cs_n` is low. The change is visible after the third rising clock edge following the change on `rd_n`.
- R4: A qualified rising edge of `rd_n` advances the pointer by one channel. `data_o` shows the next channel after the third rising clock edge following the change on `rd_n`.
- R5: After a qualified read of the last converted channel (channel k+1 for code k), the pointer returns to channel 1.
- R6: With count code 0 (single channel), every read returns channel 1's result.
- R7: Strobes on `rd_n` while `cs_n` is high change neither the pointer nor `int_n`.
- R8: Reads beyond n before the next conversion keep cycling from channel 1 in channel order.
- R9: When `done_i` coincides with a detected read edge, `done_i` wins: the pointer goes to channel 1 and `int_n` goes to 0.
- R10: `data_o` carries the stored 14-bit value bit for bit, including negative two's-complement values. Channel c occupies bits [14c+13:14c] of `results_i`, with c counted from 0.
- R11: Changes on `chan_cnt_i` between `done_i` pulses do not alter the wrap point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_i | input | 1 | One-cycle conversion-complete strobe |
| results_i | input | 56 | Results of all channels; channel c at [14c+13:14c] |
| chan_cnt_i | input | 2 | Channel-count code: number of channels minus one |
| cs_n | input | 1 | Active-low chip-select (asynchronous) |
| rd_n | input | 1 | Active-low read strobe (asynchronous) |
| data_o | output | 14 | Result at the current pointer |
| int_n | output | 1 | Active-low conversion-ready interrupt |

## Verification
A `done_i` pulse shows on `int_n` and on the pointer one rising edge later. A change on `rd_n` shows after three rising edges: two synchronizer stages, then the state register. The bench drives every input on the falling clock edge and samples on a falling edge. Normal reads hold each strobe level for four cycles, so samples fall clear of the three-edge window. Dedicated scenarios sample after exactly two and exactly three edges to pin down the latency. They also place `done_i` on the very edge where a read edge takes effect.

// File: rtl/readout_pkg.sv
package readout_pkg;

   // Qualified strobe events produced by the synchronizer, one cycle wide.
   typedef struct packed {
      logic fall;   // read strobe went low while selected
      logic rise;   // read strobe went high while selected
   } strobe_evt_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/rd_edge_sync.sv
module rd_edge_sync
   import readout_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rd_n,
   input  logic        cs_n,
   output strobe_evt_t evt
);

   localparam int unsigned MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_depth
      $error("rd_edge_sync: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] rd_sh;
   logic [SYNC_STAGES-1:0] cs_sh;
   logic                   rd_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_sh   <= '1;
         cs_sh   <= '1;
         rd_prev <= 1'b1;
      end else begin
         rd_sh   <= {rd_sh[SYNC_STAGES-2:0], rd_n};
         cs_sh   <= {cs_sh[SYNC_STAGES-2:0], cs_n};
         rd_prev <= rd_sh[MSB];
      end
   end

   logic sel;
   assign sel = ~cs_sh[MSB];

   always_comb begin
      evt.fall = sel &  rd_prev & ~rd_sh[MSB];
      evt.rise = sel & ~rd_prev &  rd_sh[MSB];
   end

endmodule

// File: rtl/result_bank.sv
module result_bank #(
   parameter int unsigned DATA_W     = 14,
   parameter int unsigned NUM_CH     = 4,
   parameter bit          RESET_DATA = 1'b1,
   localparam int unsigned PTR_W     = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [NUM_CH*DATA_W-1:0] results_flat,
   input  logic [PTR_W-1:0]         sel,
   output logic [DATA_W-1:0]        rd_data
);

   logic [DATA_W-1:0] bank [NUM_CH];

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    bank[g] <= '0;
            else if (load) bank[g] <= results_flat[g*DATA_W +: DATA_W];
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (load) bank[g] <= results_flat[g*DATA_W +: DATA_W];
         end
      end
   end

   assign rd_data = bank[sel];

endmodule

// File: rtl/read_ctrl.sv
module read_ctrl
   import readout_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned PTR_W = $clog2(NUM_CH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             done,
   input  logic [PTR_W-1:0] cnt_code,
   input  strobe_evt_t      evt,
   output logic [PTR_W-1:0] ptr,
   output logic [PTR_W-1:0] last,
   output logic             int_n
);

   localparam bit POW2 = ((1 << PTR_W) == NUM_CH);

   logic [PTR_W-1:0] last_d;

   if (POW2) begin : g_direct
      assign last_d = cnt_code;
   end else begin : g_clamp
      localparam logic [PTR_W-1:0] TOP = PTR_W'(NUM_CH - 1);
      assign last_d = (cnt_code > TOP) ? TOP : cnt_code;
   end

   logic [PTR_W-1:0] ptr_next;
   assign ptr_next = (ptr == last) ? '0 : ptr + PTR_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         last  <= '0;
         int_n <= 1'b1;
      end else if (done) begin
         ptr   <= '0;
         last  <= last_d;
         int_n <= 1'b0;
      end else begin
         if (evt.fall && !int_n) int_n <= 1'b1;
         if (evt.rise)           ptr   <= ptr_next;
      end
   end

endmodule

// File: rtl/chan_readout.sv
module chan_readout
   import readout_pkg::*;
#(
   parameter int unsigned DATA_W      = 14,
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RESET_DATA  = 1'b1,
   localparam int unsigned PTR_W      = $clog2(NUM_CH)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     done_i,
   input  logic [NUM_CH*DATA_W-1:0] results_i,
   input  logic [PTR_W-1:0]         chan_cnt_i,
   input  logic                     cs_n,
   input  logic                     rd_n,
   output logic [DATA_W-1:0]        data_o,
   output logic                     int_n
);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("chan_readout: NUM_CH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("chan_readout: DATA_W must be positive");
   end

   strobe_evt_t      evt;
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] last_q;

   rd_edge_sync #(
      .SYNC_STAGES(SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_n  (rd_n),
      .cs_n  (cs_n),
      .evt   (evt)
   );

   read_ctrl #(
      .NUM_CH(NUM_CH)
   ) i_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done_i),
      .cnt_code (chan_cnt_i),
      .evt      (evt),
      .ptr      (ptr_q),
      .last     (last_q),
      .int_n    (int_n)
   );

   result_bank #(
      .DATA_W     (DATA_W),
      .NUM_CH     (NUM_CH),
      .RESET_DATA (RESET_DATA)
   ) i_bank (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (done_i),
      .results_flat (results_i),
      .sel          (ptr_q),
      .rd_data      (data_o)
   );

endmodule

// File: rtl/chan_readout_chk.sv
module chan_readout_chk
   import readout_pkg::*;
#(
   parameter int unsigned PTR_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done_i,
   input logic             int_n,
   input strobe_evt_t      evt,
   input logic [PTR_W-1:0] ptr,
   input logic [PTR_W-1:0] last
);

   // R2: completion pulls the interrupt low and homes the pointer
   a_r2_int_low: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !int_n);
   a_r2_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> (ptr == '0));

   // R3: a selected falling edge releases a pending interrupt
   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_n && !done_i && evt.fall) |=> int_n);
   a_r3_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_n && !done_i && !evt.fall) |=> !int_n);
   a_r3_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (int_n && !done_i) |=> int_n);

   // R4: a selected rising edge steps the pointer
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.rise && !done_i && ptr != last) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

   // R5: the read of the last converted channel wraps to channel 1
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.rise && !done_i && ptr == last) |=> (ptr == '0));
   a_r5_bound: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= last);

   // R7: no selected edge, no pointer movement
   a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt.rise && !done_i) |=> $stable(ptr));

   // R11: the wrap point only changes on completion
   a_r11_last_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> $stable(last));

endmodule

bind chan_readout chan_readout_chk #(
   .PTR_W(PTR_W)
) i_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .done_i (done_i),
   .int_n  (int_n),
   .evt    (evt),
   .ptr    (ptr_q),
   .last   (last_q)
);

// File: tb/test_chan_readout.sv
module test_chan_readout;

   localparam int W = 14;
   localparam int N = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           done_i = 1'b0;
   logic [N*W-1:0] results_i = '0;
   logic [1:0]     chan_cnt_i = 2'd0;
   logic           cs_n = 1'b1;
   logic           rd_n = 1'b1;
   logic [W-1:0]   data_o;
   logic           int_n;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;   // 250 MHz

   chan_readout i_chan_readout (
      .clk        (clk),
      .rst_n      (rst_n),
      .done_i     (done_i),
      .results_i  (results_i),
      .chan_cnt_i (chan_cnt_i),
      .cs_n       (cs_n),
      .rd_n       (rd_n),
      .data_o     (data_o),
      .int_n      (int_n)
   );

   logic [W-1:0] vals [N];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic load(input logic [W-1:0] v0, v1, v2, v3, input logic [1:0] code);
      @(negedge clk);
      vals[0] = v0; vals[1] = v1; vals[2] = v2; vals[3] = v3;
      results_i  = {v3, v2, v1, v0};
      chan_cnt_i = code;
      done_i     = 1'b1;
      @(negedge clk);
      done_i     = 1'b0;
   endtask

   // One selected read; returns the data seen while the strobe is low.
   task automatic rd_pulse(output logic [W-1:0] d);
      @(negedge clk);
      cs_n = 1'b0;
      @(negedge clk);
      rd_n = 1'b0;
      repeat (4) @(negedge clk);
      d = data_o;
      rd_n = 1'b1;
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic t_reset();
      chk("R1 int_n after reset", int_n, 1);
   endtask

   task automatic t_four();
      logic [W-1:0] d;
      load(14'h1ABC, 14'h2001, 14'h0005, 14'h3FFF, 2'd3);
      chk("R2 int_n low after done", int_n, 0);
      for (int i = 0; i < N; i++) begin
         rd_pulse(d);
         chk($sformatf("R10 four-channel read %0d", i), d, vals[i]);
         if (i == 0) chk("R3 int_n released by first read", int_n, 1);
      end
      rd_pulse(d);
      chk("R5 wrap after four reads", d, vals[0]);
      rd_pulse(d);
      chk("R8 extra reads keep cycling", d, vals[1]);
   endtask

   task automatic t_latency();
      load(14'h0111, 14'h0222, 14'h0333, 14'h0444, 2'd3);
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk); rd_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R3 int_n still low after two edges", int_n, 0);
      @(posedge clk); @(negedge clk);
      chk("R3 int_n high after three edges", int_n, 1);
      repeat (2) @(negedge clk);
      rd_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      chk("R4 data unchanged after two edges", data_o, 14'h0111);
      @(posedge clk); @(negedge clk);
      chk("R4 next channel after three edges", data_o, 14'h0222);
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
   endtask

   task automatic t_single();
      logic [W-1:0] d;
      load(14'h2AAA, 14'h1555, 14'h0F0F, 14'h00FF, 2'd0);
      for (int i = 0; i < 3; i++) begin
         rd_pulse(d);
         chk($sformatf("R6 single-channel read %0d", i), d, vals[0]);
      end
   endtask

   task automatic t_counts();
      logic [W-1:0] d;
      for (int c = 1; c <= 2; c++) begin
         load(14'h0010, 14'h0020, 14'h0030, 14'h0040, 2'(c));
         for (int i = 0; i <= c + 1; i++) begin
            rd_pulse(d);
            chk($sformatf("R5 count code %0d read %0d", c, i), d, vals[i % (c + 1)]);
         end
      end
   endtask

   task automatic t_no_select();
      logic [W-1:0] d;
      load(14'h0A0A, 14'h0B0B, 14'h0C0C, 14'h0D0D, 2'd3);
      @(negedge clk); rd_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R7 int_n unaffected without select", int_n, 0);
      rd_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R7 pointer unaffected without select", data_o, 14'h0A0A);
      rd_pulse(d);
      chk("R7 first selected read is channel 1", d, 14'h0A0A);
   endtask

   task automatic t_count_change();
      logic [W-1:0] d;
      load(14'h0001, 14'h0002, 14'h0003, 14'h0004, 2'd1);
      chan_cnt_i = 2'd3;
      rd_pulse(d);
      rd_pulse(d);
      rd_pulse(d);
      chk("R11 latched count decides wrap", d, 14'h0001);
   endtask

   task automatic t_reload_mid();
      logic [W-1:0] d;
      load(14'h0100, 14'h0200, 14'h0300, 14'h0400, 2'd3);
      rd_pulse(d);
      rd_pulse(d);
      load(14'h3100, 14'h3200, 14'h3300, 14'h3400, 2'd3);
      chk("R2 reload mid-sequence raises interrupt", int_n, 0);
      rd_pulse(d);
      chk("R2 reload restarts at channel 1", d, 14'h3100);
   endtask

   task automatic t_collide();
      logic [W-1:0] d;
      load(14'h0055, 14'h0066, 14'h0077, 14'h0088, 2'd3);
      rd_pulse(d);
      // rising edge coincides with a new completion
      @(negedge clk); cs_n = 1'b0;
      @(negedge clk); rd_n = 1'b0;
      repeat (4) @(negedge clk);
      rd_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      results_i = {14'h1004, 14'h1003, 14'h1002, 14'h1001};
      done_i = 1'b1;
      @(negedge clk); done_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 done beats rising edge: pointer", data_o, 14'h1001);
      chk("R9 done beats rising edge: int_n", int_n, 0);
      // falling edge coincides with a new completion
      @(negedge clk); rd_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      done_i = 1'b1;
      @(negedge clk); done_i = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 done beats falling edge: int_n", int_n, 0);
      rd_n = 1'b1;
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_four();
      t_latency();
      t_single();
      t_counts();
      t_no_select();
      t_count_change();
      t_reload_mid();
      t_collide();
      repeat (4) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule